// File: doc/BRIEF.md
# Double-Buffered Serial DAC Word Loader

This block is the digital receive side of a serial-loaded digital-to-analog converter. A host shifts 24-bit words in over three wires: a serial clock, an active-low frame strobe and a data line. The data line is sampled on each falling serial-clock edge while the strobe is low, most significant bit first. When the strobe rises after exactly 24 such edges, the word is accepted into a holding register. It then moves on into the output register that drives the converter's parallel code.

The output register is loaded in one of two ways, chosen by the level of an active-low load pin. If the pin is low when the frame closes, the new word goes to the output at once. If the pin is high, only the holding register takes the word, and the output follows on the next falling edge of the load pin. An active-low clear pin forces the output register to a clear code supplied on a port. An active-low reset returns every register to zero. All pins are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. A second output gives the code in straight binary: it is the register value unchanged, or, when the two's-complement mode pin is high, the register value with its top bit inverted.

Top module: `dac_serial_front`

## Requirements
- R1: While `sync_n` is low, `sdin` is shifted in on each falling edge of `sclk`, MSB (bit 23) first. If `ldac_n` is low when `sync_n` rises after exactly 24 falling edges, the word appears on `dac_code` within 8 `clk` cycles.
- R2: Falling `sclk` edges while `sync_n` is high change neither `dac_code` nor the holding register.
- R3: A frame that closes after any number of falling `sclk` edges other than 24 is discarded. `dac_code` is unchanged, and a later `ldac_n` falling edge loads the previously accepted word.
- R4: If `ldac_n` is high when a valid frame closes, `dac_code` keeps its value. The next falling edge of `ldac_n` loads the held word into `dac_code`.
- R5: While `clr_n` is low, `dac_code` equals `clear_code`. Releasing `clr_n` does not reload the output, and the holding register keeps its word.
- R6: While `reset_n` is low, the holding register and `dac_code` are zero.
- R7: `code_bin` equals `dac_code` when `twos_mode` is 0. When `twos_mode` is 1, it equals `dac_code` with bit 23 inverted.
- R8: Clear has priority over loading. A valid frame with `ldac_n` low, or an `ldac_n` falling edge, while `clr_n` is low leaves `dac_code` at `clear_code`, but the frame's word is still taken into the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| reset_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load control |
| clr_n | input | 1 | Active-low clear, level sensitive |
| twos_mode | input | 1 | 1 selects two's-complement register coding |
| clear_code | input | 24 | Value forced into the output register by clear |
| dac_code | output | 24 | Output register contents |
| code_bin | output | 24 | Output code in straight binary |

## Verification
The assertions assume that every serial pin level lasts several system clocks, so each edge seen after the synchronisers matches a real pin edge. They also assume that `sdin` is settled well before each falling edge of `sclk`. The stimulus holds each `sclk` phase for four system clocks and changes `sdin` only while `sclk` is high. It pulses `ldac_n` and `clr_n` for at least six clocks, and changes `clear_code` and `twos_mode` only between operations. Random words and frame lengths are mixed with directed cases for stray clocks, clear priority and reset.

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         reset_n,
  input  logic         sclk,
  input  logic         sync_n,
  input  logic         sdin,
  input  logic         ldac_n,
  input  logic         clr_n,
  input  logic         twos_mode,
  input  logic [W-1:0] clear_code,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] code_bin
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [2:0]    sclk_p, sync_p, ldac_p;
  logic [1:0]    clr_p, sdin_p;
  logic [W-1:0]  shreg, in_reg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      sclk_p <= '1;
      sync_p <= '1;
      ldac_p <= '1;
      clr_p  <= '1;
      sdin_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sync_p <= {sync_p[1:0], sync_n};
      ldac_p <= {ldac_p[1:0], ldac_n};
      clr_p  <= {clr_p[0], clr_n};
      sdin_p <= {sdin_p[0], sdin};
    end
  end

  wire sclk_fall = sclk_p[2] & ~sclk_p[1];
  wire sync_fall = sync_p[2] & ~sync_p[1];
  wire sync_rise = ~sync_p[2] & sync_p[1];
  wire ldac_fall = ldac_p[2] & ~ldac_p[1];
  wire ldac_low  = ~ldac_p[1];
  wire clr_on    = ~clr_p[1];
  wire word_ok   = sync_rise && (cnt == FULL);

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      shreg <= '0;
      cnt   <= FULL + 1'b1;
    end else if (sync_fall) begin
      cnt <= '0;
    end else if (sclk_fall && !sync_p[1]) begin
      shreg <= {shreg[W-2:0], sdin_p[1]};
      if (cnt <= FULL) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      in_reg   <= '0;
      dac_code <= '0;
    end else begin
      if (word_ok) in_reg <= shreg;
      if (clr_on)                   dac_code <= clear_code;
      else if (word_ok && ldac_low) dac_code <= shreg;
      else if (ldac_fall)           dac_code <= in_reg;
    end
  end

  assign code_bin = twos_mode ? {~dac_code[W-1], dac_code[W-2:0]} : dac_code;
endmodule

module dac_serial_front_chk #(
  parameter int W = 24,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          reset_n,
  input logic          sync_rise,
  input logic          ldac_fall,
  input logic          ldac_low,
  input logic          clr_on,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  shreg,
  input logic [W-1:0]  in_reg,
  input logic [W-1:0]  clear_code,
  input logic [W-1:0]  dac_code
);
  assert_immediate_load_R1: assert property (@(posedge clk) disable iff (!reset_n)
    (sync_rise && cnt == CW'(W) && ldac_low && !clr_on) |=> dac_code == $past(shreg));

  assert_bad_frame_dropped_R3: assert property (@(posedge clk) disable iff (!reset_n)
    (sync_rise && cnt != CW'(W)) |=> $stable(in_reg));

  assert_output_only_on_event_R4: assert property (@(posedge clk) disable iff (!reset_n)
    (dac_code != $past(dac_code)) |-> $past(clr_on || sync_rise || ldac_fall));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!reset_n)
    clr_on |=> dac_code == $past(clear_code));
endmodule

bind dac_serial_front dac_serial_front_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .reset_n(reset_n), .sync_rise(sync_rise), .ldac_fall(ldac_fall),
  .ldac_low(ldac_low), .clr_on(clr_on), .cnt(cnt), .shreg(shreg),
  .in_reg(in_reg), .clear_code(clear_code), .dac_code(dac_code)
);

// File: tb/dac_serial_front_tb.sv
module dac_serial_front_tb;
  logic clk = 0, reset_n = 0, sclk = 1, sync_n = 1, sdin = 0;
  logic ldac_n = 0, clr_n = 1, twos_mode = 0;
  logic [23:0] clear_code = 24'h800000;
  logic [23:0] dac_code, code_bin;
  logic [23:0] exp_in = 0, exp_dac = 0;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  dac_serial_front u_dut (
    .clk(clk), .reset_n(reset_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .twos_mode(twos_mode),
    .clear_code(clear_code), .dac_code(dac_code), .code_bin(code_bin));

  function automatic logic [23:0] to_bin(logic [23:0] v, logic tm);
    return tm ? (v ^ 24'h800000) : v;
  endfunction

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req);
    checks++;
    if (dac_code !== exp_dac) begin
      errors++;
      $display("FAIL %s dac_code=%h expected=%h", req, dac_code, exp_dac);
    end
    checks++;
    if (code_bin !== to_bin(exp_dac, twos_mode)) begin
      errors++;
      $display("FAIL R7 (%s) code_bin=%h expected=%h", req, code_bin, to_bin(exp_dac, twos_mode));
    end
  endtask

  task automatic frame(logic [23:0] w, int nb);
    sync_n = 0; wt(4);
    for (int i = 0; i < nb; i++) begin
      sdin = (i < 24) ? w[23-i] : w[i%24]; wt(4);
      sclk = 0; wt(4);
      sclk = 1;
    end
    wt(4); sync_n = 1; wt(8);
    if (nb == 24) begin
      exp_in = w;
      if (!ldac_n && clr_n) exp_dac = w;
    end
  endtask

  task automatic ldac_pulse();
    ldac_n = 1; wt(6); ldac_n = 0; wt(8);
    if (clr_n) exp_dac = exp_in;
  endtask

  task automatic clr_pulse();
    clr_n = 0; wt(8); exp_dac = clear_code;
    chk("R5");
    clr_n = 1; wt(6);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    wt(3);
    chk("R6");
    reset_n = 1; wt(4);

    frame(24'hA5C3F1, 24); chk("R1");
    frame(24'h000001, 24); chk("R1");
    twos_mode = 1; wt(2); chk("R7");
    twos_mode = 0;

    ldac_n = 1; wt(4);
    frame(24'h123456, 24); chk("R4");
    ldac_n = 0; wt(8); exp_dac = exp_in; chk("R4");

    frame(24'hFFFFFF, 23); chk("R3");
    frame(24'h0F0F0F, 25); chk("R3");
    ldac_pulse(); chk("R3");

    for (int i = 0; i < 6; i++) begin
      sclk = 0; sdin = ~sdin; wt(4); sclk = 1; wt(4);
    end
    wt(6); chk("R2");
    ldac_pulse(); chk("R2");

    clear_code = 24'h3C3C3C;
    clr_pulse(); chk("R5");
    ldac_pulse(); chk("R5");

    clr_n = 0; wt(6); exp_dac = clear_code;
    frame(24'h777777, 24); chk("R8");
    ldac_n = 1; wt(6); ldac_n = 0; wt(8); chk("R8");
    clr_n = 1; wt(6); chk("R8");
    ldac_pulse(); chk("R8");

    for (int i = 0; i < 40; i++) begin
      int op = $urandom_range(0, 5);
      logic [23:0] w = 24'($urandom);
      twos_mode = 1'($urandom);
      case (op)
        0: begin ldac_n = 0; wt(2); frame(w, 24); chk("R1"); end
        1: begin ldac_n = 1; wt(2); frame(w, 24); chk("R4"); ldac_pulse(); chk("R4"); end
        2: begin frame(w, $urandom_range(1, 23)); chk("R3"); end
        3: begin frame(w, $urandom_range(25, 30)); chk("R3"); end
        4: begin clear_code = 24'($urandom); clr_pulse(); end
        default: begin ldac_pulse(); chk("R4"); end
      endcase
    end

    reset_n = 0; wt(3);
    exp_dac = 0; exp_in = 0; chk("R6");
    reset_n = 1; wt(4);
    ldac_pulse(); chk("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule